// File: doc/BRIEF.md
# Muxed-Load Serializing Shift Register

This block turns a parallel word into a serial bit stream, most significant bit first. It is meant for pixel serialization where words arrive interleaved. The parallel load path passes through a two-way word selector. One leg takes a live input word directly. The other leg takes a word held in a transparent staging latch. While the current word shifts out, the next word can be captured into the latch, so a load can follow the last shift with no gap.

On every rising clock edge the register either loads the selected word or shifts by one place. When it shifts, a serial input enters the lowest stage. The output is always the highest stage. Longer registers are built by chaining instances, with the serial output of one feeding the serial input of the next.

Top module: `pixel_serializer`

## Requirements
- R1: While `rst` is high at a rising edge, every stage clears. After that edge, `ser_out` reads 0, and further shifts with `ser_in` low keep it at 0.
- R2: With `load_en` high and `pick_direct` high at a rising edge, bit i of `word_direct` enters stage i. `ser_out` then shows bit 7 of that word.
- R3: With `load_en` high and `pick_direct` low at a rising edge, the register loads the staging latch contents, bit i into stage i.
- R4: While `hold_open` is high, the staging latch is transparent. A load taken then uses the current `word_staged` value.
- R5: The staging latch keeps the value present when `hold_open` fell. Later changes on `word_staged` while `hold_open` is low do not reach a subsequent load.
- R6: With `load_en` low at a rising edge, stage i moves into stage i+1 and `ser_in` enters stage 0. After a load, successive edges therefore present bits 7 down to 0 on `ser_out`.
- R7: `rst` takes priority over `load_en`. A load requested in a reset cycle leaves every stage cleared.
- R8: While shifting, `pick_direct` and `word_direct` have no effect on the serial stream. A new word can be latched during the shift without disturbing it.
- R9: When one instance's `ser_out` drives a second instance's `ser_in`, the second instance outputs a 16-bit stream: its own word MSB first, then the first instance's word MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all register updates on the rising edge |
| rst | input | 1 | Synchronous active-high clear of the register stages |
| load_en | input | 1 | High: parallel load; low: shift one place |
| pick_direct | input | 1 | High: load `word_direct`; low: load the latched staged word |
| hold_open | input | 1 | High: staging latch transparent; falling edge captures |
| ser_in | input | 1 | Serial data entering stage 0 during a shift |
| word_direct | input | 8 | Live parallel word |
| word_staged | input | 8 | Parallel word feeding the staging latch |
| ser_out | output | 1 | Highest register stage |

## Verification
The hardest case to reach is interleaved operation. Here the latch opens and closes partway through an 8-bit shift, its input then changes, and the latched word is loaded right after the last bit leaves. The bench loads a direct word and shifts it out. During those shifts it pulses `hold_open` around one staged value, changes `word_staged` to a different value, and toggles `pick_direct` and `word_direct`. It then checks that the first 8 bits are unchanged and that the next 8 bits are the captured word. A second instance chained behind the first checks the 16-bit cascade.

// File: rtl/serializer_pkg.sv
package serializer_pkg;

    localparam int unsigned SER_W_DEF = 8;

    typedef enum logic {
        ACT_SHIFT = 1'b0,
        ACT_LOAD  = 1'b1
    } step_act_e;

    typedef enum logic {
        SRC_STAGED = 1'b0,
        SRC_DIRECT = 1'b1
    } load_src_e;

    typedef struct packed {
        logic      clear;
        step_act_e act;
        load_src_e src;
    } step_ctrl_t;

    function automatic step_ctrl_t decode_ctrl(input logic rst,
                                               input logic load_en,
                                               input logic pick_direct);
        step_ctrl_t c;
        c.clear = rst;
        c.act   = load_en ? ACT_LOAD : ACT_SHIFT;
        c.src   = pick_direct ? SRC_DIRECT : SRC_STAGED;
        return c;
    endfunction

endpackage

// File: rtl/stage_latch.sv
module stage_latch
    import serializer_pkg::*;
#(
    parameter int unsigned W = SER_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold_open,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] word_held
);

    always_latch begin
        if (hold_open) begin
            word_held <= word_in;
        end
    end

    // R4
    latch_follow_chk: assert property (@(posedge clk) disable iff (rst)
        hold_open |-> (word_held == word_in));

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_open && $past(!hold_open)) |-> $stable(word_held));

endmodule

// File: rtl/load_mux.sv
module load_mux
    import serializer_pkg::*;
#(
    parameter int unsigned W = SER_W_DEF
) (
    input  load_src_e    src,
    input  logic [W-1:0] word_a,
    input  logic [W-1:0] word_b,
    output logic [W-1:0] word_sel
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign word_sel[i] = (src == SRC_DIRECT) ? word_a[i] : word_b[i];
    end

endmodule

// File: rtl/shift_core.sv
module shift_core
    import serializer_pkg::*;
#(
    parameter int unsigned W = SER_W_DEF
) (
    input  logic         clk,
    input  logic         clear,
    input  step_act_e    act,
    input  logic [W-1:0] par_word,
    input  logic         ser_in,
    output logic [W-1:0] stages
);

    always_ff @(posedge clk) begin
        if (clear) begin
            stages <= '0;
        end else if (act == ACT_LOAD) begin
            stages <= par_word;
        end else begin
            stages <= {stages[W-2:0], ser_in};
        end
    end

    // R1
    clear_chk: assert property (@(posedge clk)
        clear |=> (stages == '0));

    // R2
    load_chk: assert property (@(posedge clk) disable iff (clear)
        (act == ACT_LOAD) |=> (stages == $past(par_word)));

    // R6
    shift_chk: assert property (@(posedge clk) disable iff (clear)
        (act == ACT_SHIFT) |=> (stages == {$past(stages[W-2:0]), $past(ser_in)}));

endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
    import serializer_pkg::*;
#(
    parameter int unsigned W = SER_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic         pick_direct,
    input  logic         hold_open,
    input  logic         ser_in,
    input  logic [W-1:0] word_direct,
    input  logic [W-1:0] word_staged,
    output logic         ser_out
);

    step_ctrl_t   ctrl;
    logic [W-1:0] held_word;
    logic [W-1:0] sel_word;
    logic [W-1:0] stages;

    assign ctrl = decode_ctrl(rst, load_en, pick_direct);

    stage_latch #(.W(W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .hold_open (hold_open),
        .word_in   (word_staged),
        .word_held (held_word)
    );

    load_mux #(.W(W)) u_mux (
        .src      (ctrl.src),
        .word_a   (word_direct),
        .word_b   (held_word),
        .word_sel (sel_word)
    );

    shift_core #(.W(W)) u_core (
        .clk      (clk),
        .clear    (ctrl.clear),
        .act      (ctrl.act),
        .par_word (sel_word),
        .ser_in   (ser_in),
        .stages   (stages)
    );

    assign ser_out = stages[W-1];

    // R7
    reset_priority_chk: assert property (@(posedge clk)
        (rst && load_en) |=> !ser_out);

endmodule

// File: tb/pixel_serializer_tb.sv
`timescale 1ns/1ps
module pixel_serializer_tb;

    logic       clk = 1'b0;
    logic       rst, load_en, pick_direct, hold_open, ser_in;
    logic [7:0] word_direct, word_staged, word_direct_hi;
    logic       ser_out, ser_out_hi;
    int         checks = 0;
    int         errors = 0;

    always #2 clk = ~clk;

    pixel_serializer u_dut (
        .clk(clk), .rst(rst), .load_en(load_en), .pick_direct(pick_direct),
        .hold_open(hold_open), .ser_in(ser_in), .word_direct(word_direct),
        .word_staged(word_staged), .ser_out(ser_out)
    );

    pixel_serializer u_dut_hi (
        .clk(clk), .rst(rst), .load_en(load_en), .pick_direct(pick_direct),
        .hold_open(hold_open), .ser_in(ser_out), .word_direct(word_direct_hi),
        .word_staged(word_staged), .ser_out(ser_out_hi)
    );

    typedef struct packed {
        logic       rst;
        logic       pe;
        logic       sel;
        logic       le;
        logic       si;
        logic [7:0] a;
        logic [7:0] b;
        logic       exp;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0}, // R7 reset beats load
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hA5, 8'h3C, 1'b1}, // R2 load A5
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5, 8'h3C, 1'b0}, // R6 -> 4A
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5, 8'h3C, 1'b1}, // R6 -> 95, latch closes on 3C
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5, 8'hFF, 1'b0}, // R6 -> 2A
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0}, // R5 load held 3C
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0}, // R3 -> 78
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b1}, // R3 -> F0
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'hC3, 1'b1}, // R4 transparent C3
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h7F, 8'hC3, 1'b0}  // R2 load 7F
    };

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0]  first_w;
        logic [7:0]  staged_w;
        logic [15:0] chain_w;

        rst = 1'b1; load_en = 1'b0; pick_direct = 1'b0; hold_open = 1'b0;
        ser_in = 1'b0; word_direct = 8'h00; word_staged = 8'h00;
        word_direct_hi = 8'h00;
        step();
        step();
        check("R1 reset state", ser_out, 1'b0);

        for (int v = 0; v < 10; v++) begin
            rst = VECS[v].rst; load_en = VECS[v].pe; pick_direct = VECS[v].sel;
            hold_open = VECS[v].le; ser_in = VECS[v].si;
            word_direct = VECS[v].a; word_staged = VECS[v].b;
            step();
            check($sformatf("R2-R7 table row %0d", v), ser_out, VECS[v].exp);
        end

        // R1: clear, then shifting zeros keeps the output low
        rst = 1'b0; load_en = 1'b1; pick_direct = 1'b1; word_direct = 8'hFF;
        step();
        check("R2 load FF", ser_out, 1'b1);
        rst = 1'b1;
        step();
        check("R1 clear after FF", ser_out, 1'b0);
        rst = 1'b0; load_en = 1'b0; ser_in = 1'b0;
        for (int k = 0; k < 7; k++) begin
            step();
            check("R1 stages all cleared", ser_out, 1'b0);
        end

        // Interleaved: shift direct word while staging a new one (R5 R6 R8)
        first_w = 8'hD2; staged_w = 8'h5B;
        hold_open = 1'b0; load_en = 1'b1; pick_direct = 1'b1; word_direct = first_w;
        step();
        check("R2 interleave load", ser_out, first_w[7]);
        load_en = 1'b0;
        for (int k = 1; k < 8; k++) begin
            pick_direct = k[0];
            word_direct = 8'h11 * k[7:0];
            if (k == 1) begin
                hold_open = 1'b1; word_staged = staged_w;
            end else if (k == 2) begin
                hold_open = 1'b0;
            end else if (k == 3) begin
                word_staged = 8'h00;
            end
            step();
            check("R8 shift stream undisturbed", ser_out, first_w[7-k]);
        end
        load_en = 1'b1; pick_direct = 1'b0; word_direct = 8'hFF;
        step();
        check("R5 load of captured word", ser_out, staged_w[7]);
        load_en = 1'b0;
        for (int k = 1; k < 8; k++) begin
            step();
            check("R6 staged word stream", ser_out, staged_w[7-k]);
        end

        // Two-instance cascade (R9)
        chain_w = 16'hE196;
        load_en = 1'b1; pick_direct = 1'b1; ser_in = 1'b0;
        word_direct_hi = chain_w[15:8]; word_direct = chain_w[7:0];
        step();
        check("R9 cascade bit 15", ser_out_hi, chain_w[15]);
        load_en = 1'b0;
        for (int k = 1; k < 16; k++) begin
            step();
            check("R9 cascade stream", ser_out_hi, chain_w[15-k]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule